// File: doc/BRIEF.md
# SD SPI Command Framer and Response Poller

This block runs one command transaction to a memory card in SPI mode. A requester pulses `start` with a 6-bit command index, a 32-bit argument and a response kind. The block then lowers chip-select and waits for the card to report ready. It sends the six-byte command frame, searches a bounded window of fill bytes for the status byte, and collects any trailing bytes the response kind calls for. At the end it raises chip-select and clocks one more fill byte. It returns the status byte, an optional 32-bit word and decoded error flags, then pulses `done`.

Every byte passes through an external byte shifter over a request/acknowledge pair. `spi_req` is held with a stable `spi_tx`. The byte counts as exchanged in the cycle where `spi_req` and `spi_ack` are both high, and `spi_rx` carries the received byte in that same cycle. `spi_req` may stay high for back-to-back bytes. CRC is not computed: the checksum byte is a fixed value chosen by the command index.

Top module: `sd_cmd_framer`

## Requirements
- R1: The frame is six bytes. The first is `0x40 | index`. Bytes two to five carry the argument with the most significant byte first. The sixth is the checksum byte.
- R2: The checksum byte is 0x95 for index 0, 0x87 for index 8, and 0xFF for any other index, so bit 0 of that byte is always 1.
- R3: Before the frame, for any index except 12, the block clocks 0xFF until it receives 0xFF. It stops after `rdy_limit` bytes (a limit of 0 counts as 1) and proceeds to the frame either way.
- R4: After the frame, the block clocks 0xFF for at most 16 bytes. The first received byte with bit 7 clear is the status byte, returned on `r1`.
- R5: If none of the 16 bytes is valid, the frame and search are repeated, for at most 3 attempts in total. After that, `r1` is 0xFF and `no_resp` is 1, while `crc_err`, `illegal`, `erase_err` and `param_err` are 0.
- R6: For index 12, the ready wait is skipped. After each frame, exactly one byte is clocked and discarded, even if its bit 7 is clear, before the response search begins.
- R7: With `rsp_kind` = 2, four more bytes are read and packed into `rsp_word`, first byte in bits 31:24. Otherwise, or when the transaction ends early, `rsp_word` is 0.
- R8: With `rsp_kind` = 1, after the status byte the block clocks 0xFF until it receives 0xFF, bounded by `rdy_limit` bytes as in R3. `rsp_kind` 0 and 3 take no trailing bytes.
- R9: The flags decode the status byte: `crc_err` is bit 3, `illegal` is bit 2, `erase_err` is bit 1 or bit 4, and `param_err` is bit 5 or bit 6. If bit 2 or bit 3 is set, no trailing bytes are read.
- R10: `cs_n` is low for every byte of the transaction and high while idle. One final 0xFF is exchanged with `cs_n` high. `done` then pulses for one cycle, as `busy` falls.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0/3 status only, 1 status then busy wait, 2 status then 4 bytes |
| rdy_limit | input | TW | Byte bound for the ready and busy waits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| spi_req | output | 1 | Byte exchange request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Byte exchange complete |
| spi_rx | input | 8 | Byte received, valid with `spi_ack` |
| cs_n | output | 1 | Card select, active low |
| r1 | output | 8 | Status byte (0xFF on no response) |
| rsp_word | output | 32 | Trailing response word |
| no_resp | output | 1 | No valid status byte after all attempts |
| crc_err | output | 1 | Status bit 3 |
| illegal | output | 1 | Status bit 2 |
| erase_err | output | 1 | Status bit 1 or 4 |
| param_err | output | 1 | Status bit 5 or 6 |

## Verification
Almost any fault in the internal state shows up at once in the byte stream. A wrong phase or byte counter adds, drops or reorders bytes on `spi_tx`, or flips `cs_n` on a byte. The bench compares the whole logged stream, each byte with its select level, against a stream built from the requirements. A fault in the status capture or the retry count shows up only at `done`, as a wrong `r1`, flag or `rsp_word`, or as an extra 22-byte attempt, so those values are checked at the end of each transaction.

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer #(
  parameter int TW         = 16,
  parameter int POLL_TRIES = 16,
  parameter int RETRIES    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    cmd_idx,
  input  logic [31:0]   cmd_arg,
  input  logic [1:0]    rsp_kind,
  input  logic [TW-1:0] rdy_limit,
  output logic          busy,
  output logic          done,
  output logic          spi_req,
  output logic [7:0]    spi_tx,
  input  logic          spi_ack,
  input  logic [7:0]    spi_rx,
  output logic          cs_n,
  output logic [7:0]    r1,
  output logic [31:0]   rsp_word,
  output logic          no_resp,
  output logic          crc_err,
  output logic          illegal,
  output logic          erase_err,
  output logic          param_err
);
  localparam int RW = $clog2(RETRIES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RDY, S_FRM, S_STF, S_POLL, S_TAIL, S_BSY, S_DES
  } st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic [RW-1:0] tries;
  logic [5:0]    idx_q;
  logic [31:0]   arg_q;
  logic [1:0]    kind_q;
  logic          nr_q;
  logic          xfer;
  logic          lim_hit;
  logic [7:0]    crc_byte;
  logic [7:0]    frm_byte;

  assign xfer     = spi_req & spi_ack;
  assign lim_hit  = ({1'b0, cnt} + 1'b1) >= {1'b0, rdy_limit};
  assign busy     = (st != S_IDLE);
  assign spi_req  = busy;
  assign cs_n     = (st == S_IDLE) || (st == S_DES);
  assign crc_byte = (idx_q == 6'd0) ? 8'h95 : (idx_q == 6'd8) ? 8'h87 : 8'hFF;

  always_comb begin
    case (cnt[2:0])
      3'd0:    frm_byte = {2'b01, idx_q};
      3'd1:    frm_byte = arg_q[31:24];
      3'd2:    frm_byte = arg_q[23:16];
      3'd3:    frm_byte = arg_q[15:8];
      3'd4:    frm_byte = arg_q[7:0];
      default: frm_byte = crc_byte;
    endcase
  end

  assign spi_tx    = (st == S_FRM) ? frm_byte : 8'hFF;
  assign no_resp   = nr_q;
  assign crc_err   = ~nr_q & r1[3];
  assign illegal   = ~nr_q & r1[2];
  assign erase_err = ~nr_q & (r1[1] | r1[4]);
  assign param_err = ~nr_q & (r1[5] | r1[6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      tries    <= '0;
      idx_q    <= '0;
      arg_q    <= '0;
      kind_q   <= '0;
      nr_q     <= 1'b0;
      r1       <= 8'hFF;
      rsp_word <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          idx_q    <= cmd_idx;
          arg_q    <= cmd_arg;
          kind_q   <= rsp_kind;
          nr_q     <= 1'b0;
          r1       <= 8'hFF;
          rsp_word <= '0;
          tries    <= '0;
          cnt      <= '0;
          st       <= (cmd_idx == 6'd12) ? S_FRM : S_RDY;
        end
      end else if (xfer) begin
        case (st)
          S_RDY: begin
            cnt <= cnt + 1'b1;
            if (spi_rx == 8'hFF || lim_hit) begin
              cnt <= '0;
              st  <= S_FRM;
            end
          end
          S_FRM: begin
            if (cnt == TW'(5)) begin
              cnt <= '0;
              st  <= (idx_q == 6'd12) ? S_STF : S_POLL;
            end else cnt <= cnt + 1'b1;
          end
          S_STF: st <= S_POLL;
          S_POLL: begin
            if (!spi_rx[7]) begin
              r1  <= spi_rx;
              cnt <= '0;
              if (spi_rx[3] || spi_rx[2]) st <= S_DES;
              else if (kind_q == 2'd2)    st <= S_TAIL;
              else if (kind_q == 2'd1)    st <= S_BSY;
              else                        st <= S_DES;
            end else if (cnt == TW'(POLL_TRIES - 1)) begin
              cnt <= '0;
              if (tries == RW'(RETRIES - 1)) begin
                r1   <= 8'hFF;
                nr_q <= 1'b1;
                st   <= S_DES;
              end else begin
                tries <= tries + 1'b1;
                st    <= S_FRM;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_TAIL: begin
            rsp_word <= {rsp_word[23:0], spi_rx};
            if (cnt == TW'(3)) st <= S_DES;
            else cnt <= cnt + 1'b1;
          end
          S_BSY: begin
            cnt <= cnt + 1'b1;
            if (spi_rx == 8'hFF || lim_hit) st <= S_DES;
          end
          default: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        endcase
      end
    end
  end

  a_r10_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !spi_req));
  a_r10_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(idx_q) && $stable(arg_q));
  a_r2_end_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FRM && cnt == TW'(5)) |-> spi_tx[0]);
  a_r5_noresp_byte: assert property (@(posedge clk) disable iff (!rst_n)
    no_resp |-> (r1 == 8'hFF));
  a_r4_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (cnt < TW'(POLL_TRIES)));
  a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tries < RW'(RETRIES)));
endmodule

// File: tb/sd_cmd_framer_tb.sv
module sd_cmd_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0] rsp_kind = '0;
  logic [TW-1:0] rdy_limit = 16'd1000;
  logic busy, done, spi_req, spi_ack, cs_n;
  logic [7:0] spi_tx, spi_rx, r1;
  logic [31:0] rsp_word;
  logic no_resp, crc_err, illegal, erase_err, param_err;

  int n_run = 0, n_fail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_framer #(.TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .rsp_kind(rsp_kind), .rdy_limit(rdy_limit), .busy(busy), .done(done),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx), .cs_n(cs_n),
    .r1(r1), .rsp_word(rsp_word), .no_resp(no_resp), .crc_err(crc_err),
    .illegal(illegal), .erase_err(erase_err), .param_err(param_err));

  // card model: acknowledges every second requested cycle, replays a script, logs traffic
  logic [7:0] script [128];
  logic [7:0] log_tx [128];
  logic       log_cs [128];
  logic [7:0] exp_tx [128];
  logic       exp_cs [128];
  int  pos = 0;
  logic dly = 1'b0, clr = 1'b0;

  initial begin spi_ack = 1'b0; spi_rx = 8'hFF; end

  always @(posedge clk) begin
    spi_ack <= 1'b0;
    if (clr) begin
      pos <= 0; dly <= 1'b0;
    end else if (spi_req && !spi_ack) begin
      if (dly) begin
        spi_ack <= 1'b1;
        spi_rx  <= (pos < 128) ? script[pos] : 8'hFF;
        if (pos < 128) begin log_tx[pos] <= spi_tx; log_cs[pos] <= cs_n; end
        pos <= pos + 1;
        dly <= 1'b0;
      end else dly <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // {idx, arg, kind, status byte, fill bytes before status}
  localparam logic [51:0] VEC [7] = '{
    {6'd0,  32'h0000_0000, 2'd0, 8'h01, 4'd0},
    {6'd8,  32'h0000_01AA, 2'd2, 8'h01, 4'd3},
    {6'd17, 32'h0000_1200, 2'd0, 8'h24, 4'd1},
    {6'd58, 32'h0000_0000, 2'd2, 8'h08, 4'd15},
    {6'd12, 32'h0000_0000, 2'd1, 8'h00, 4'd2},
    {6'd38, 32'h0000_0000, 2'd1, 8'h12, 4'd0},
    {6'd16, 32'h0000_0200, 2'd0, 8'h40, 4'd0}
  };

  task automatic run(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                     input logic [7:0] st, input int npoll, input int pre, input int nbz,
                     input int tmo, input bit nr, input bit mid, input string tag);
    int p = 0;
    int lim;
    int t;
    int w;
    bit ok;
    bit tail;
    logic [7:0] f [6];
    logic [31:0] ew;
    lim = (tmo < 1) ? 1 : tmo;
    f[0] = {2'b01, idx}; f[1] = arg[31:24]; f[2] = arg[23:16]; f[3] = arg[15:8]; f[4] = arg[7:0];
    f[5] = (idx == 6'd0) ? 8'h95 : (idx == 6'd8) ? 8'h87 : 8'hFF;
    for (int i = 0; i < 128; i++) begin script[i] = 8'hFF; exp_tx[i] = 8'hFF; exp_cs[i] = 1'b0; end
    if (idx != 6'd12) begin
      t = (pre + 1 < lim) ? pre + 1 : lim;
      for (int i = 0; i < t; i++) begin script[p] = (i < pre) ? 8'h00 : 8'hFF; p++; end
    end
    for (int a = 0; a < (nr ? 3 : 1); a++) begin
      for (int i = 0; i < 6; i++) begin exp_tx[p] = f[i]; p++; end
      if (idx == 6'd12) begin script[p] = 8'h00; p++; end
      if (nr) p = p + 16;
      else begin
        p = p + npoll;
        script[p] = st; p++;
      end
    end
    ew = 32'h0;
    tail = !nr && !(st[3] || st[2]);
    if (tail && kind == 2'd2) begin
      script[p] = 8'h12; script[p+1] = 8'h34; script[p+2] = 8'h56; script[p+3] = 8'h78;
      p = p + 4; ew = 32'h1234_5678;
    end else if (tail && kind == 2'd1) begin
      t = (nbz + 1 < lim) ? nbz + 1 : lim;
      for (int i = 0; i < t; i++) begin script[p] = (i < nbz) ? 8'h00 : 8'hFF; p++; end
    end
    exp_cs[p] = 1'b1; p++;

    clr = 1'b1; @(negedge clk); clr = 1'b0;
    cmd_idx = idx; cmd_arg = arg; rsp_kind = kind; rdy_limit = TW'(tmo);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (mid) begin
      repeat (12) @(negedge clk);
      cmd_idx = 6'd5; cmd_arg = 32'hDEAD_BEEF; rsp_kind = 2'd2;
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk(done && !busy, tag, "R10 done pulse with busy low", {30'b0, done, busy}, 32'h2);
    chk(pos == p, tag, "byte count", pos, p);
    ok = 1'b1;
    for (int i = 0; i < p && i < 128; i++)
      if (log_tx[i] !== exp_tx[i] || log_cs[i] !== exp_cs[i]) begin
        if (ok) $display("FAIL %s R1 byte %0d: actual %h/%b expected %h/%b",
                         tag, i, log_tx[i], log_cs[i], exp_tx[i], exp_cs[i]);
        ok = 1'b0;
      end
    n_run++; if (!ok) n_fail++;
    chk(r1 == (nr ? 8'hFF : st), tag, "R4 status byte", r1, nr ? 8'hFF : st);
    chk(rsp_word == ew, tag, "R7 word", rsp_word, ew);
    chk({no_resp, crc_err, illegal, erase_err, param_err} ==
        (nr ? 5'b10000 : {1'b0, st[3], st[2], st[1] | st[4], st[5] | st[6]}),
        tag, "R9 flags", {27'b0, no_resp, crc_err, illegal, erase_err, param_err},
        nr ? 32'h10 : {27'b0, 1'b0, st[3], st[2], st[1] | st[4], st[5] | st[6]});
    @(negedge clk);
    chk(!done && cs_n, tag, "R10 single done", {30'b0, done, cs_n}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !busy && !done && !spi_req, "reset", "R10 idle outputs",
        {28'b0, cs_n, busy, done, spi_req}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 7; v++)
      run(VEC[v][51:46], VEC[v][45:14], VEC[v][13:12], VEC[v][11:4], int'(VEC[v][3:0]),
          0, 2, 1000, 1'b0, 1'b0, "R1 R2 R6 R8 table");
    run(6'd55, 32'h0, 2'd0, 8'h00, 0, 0, 0, 1000, 1'b1, 1'b0, "R5 no response");
    run(6'd41, 32'h4000_0000, 2'd0, 8'h00, 0, 2, 0, 1000, 1'b0, 1'b0, "R3 ready after busy");
    run(6'd9, 32'h0, 2'd0, 8'h00, 0, 6, 0, 4, 1'b0, 1'b0, "R3 ready limit");
    run(6'd38, 32'h0, 2'd1, 8'h00, 0, 0, 9, 3, 1'b0, 1'b0, "R8 busy limit");
    run(6'd12, 32'h0, 2'd1, 8'h00, 0, 0, 1, 1000, 1'b1, 1'b0, "R6 R5 stuff on retry");
    run(6'd8, 32'hCAFE_01AA, 2'd2, 8'h01, 4, 0, 0, 1000, 1'b0, 1'b1, "R11 start while busy");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule